// File: doc/BRIEF.md
# Dual-Comparator General-Purpose Timer

This block is a single 16-bit up-counting timer channel. Software reaches it through a word-wide register port that holds two compare values, the live count and a setup word. The setup word selects the source of the count enable, a slow or a fast reference strobe, and divides that strobe by a power of two. It also gives each of the two comparators one of four modes. The count runs while the enable bit is set.

Each comparator drives a status flag. In the equality and greater-or-equal modes the flag tracks the comparison. In event mode the flag is sticky and raises the interrupt output. It is cleared by writing one to it. A comparator-2 event also sends the counter back to zero, so a single setup write produces a periodic interrupt. The period is the comparator-2 value plus one prescaled ticks. The configuration part of the setup word can be written only once after reset.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset every register (address 0 compare-1 value, address 1 compare-2 value, address 2 count, address 3 setup) reads zero, and `irq_o` is low.
- R2: While setup bit 15 is set, the count rises by one on each prescaled tick. Setup bits 3:0 hold n, and one tick is issued for every 2^n strobes of the chosen source. The prescaler is cleared at reset and on every count write.
- R3: Setup bit 4 selects the count source. A value of 1 selects `fast_tick_i` and a value of 0 selects `slow_tick_i`. The unselected strobe has no effect on the count.
- R4: Only the first setup write after reset stores bits 11:0, and later writes leave those bits unchanged. Bit 12 is read-only. It reads 0 until the first setup write and reads 1 after it.
- R5: Setup bit 15 can be written at any time. Clearing it freezes the count at its current value and does not reset it.
- R6: A write to address 2 loads the count at the next clock edge and overrides any increment or restart in that cycle.
- R7: Comparator k takes its mode from setup bits [7:6] for k=1 and [9:8] for k=2. The encoding is 00 off, 01 equal, 10 greater-or-equal and 11 event. Its status is setup bit 13 for k=1 and bit 14 for k=2. With mode off the status stays 0. In modes 01 and 10 the status shows the comparison of the count against the compare value, one cycle after the count is in place.
- R8: With comparator 2 in event mode, a tick that finds the count at or above the compare-2 value sets the comparator-2 status and returns the count to zero at the same edge. The period is therefore compare-2 value plus one ticks.
- R9: In event mode, writing 1 to a status bit in a setup write clears it and writing 0 leaves it set. A new event in the same cycle takes priority over the clear.
- R10: `irq_o` is high exactly while at least one comparator in event mode has its status set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | Slow reference count strobe |
| fast_tick_i | input | 1 | Fast reference count strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select (0 compare 1, 1 compare 2, 2 count, 3 setup) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request from event-mode status |

## Verification
A register write lands at the clock edge that follows its strobe, and read data is combinational. The bench therefore reads a written value at the falling edge right after that rising edge. The count is due one edge after the tick that caused it, so after K enabled edges with the fast strobe held high it reads K shifted right by n. A status flag in equal or greater-or-equal mode lags the count by one more edge, and the bench waits that extra edge before it reads it. Event status and the count restart appear together, with `irq_o`, at the edge of the tick that found the count at or above the compare-2 value. The bench counts edges from the setup write and samples exactly there.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 2;
    localparam int CFG_W   = 12;
    localparam int SHIFT_W = 4;
    localparam int N_CMP   = 2;

    localparam logic [ADDR_W-1:0] ADDR_CMP1  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CMP2  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_SETUP = 2'd3;

    localparam int BIT_EN     = 15;
    localparam int BIT_ST_LO  = 13;
    localparam int BIT_LOCKED = 12;
    localparam int BIT_MODE_LO = 6;
    localparam int BIT_SEL    = 4;

    typedef enum logic [1:0] {
        CMP_OFF = 2'b00,
        CMP_EQ  = 2'b01,
        CMP_GE  = 2'b10,
        CMP_EVT = 2'b11
    } cmp_mode_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SHIFT_W = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               slow_i,
    input  logic               fast_i,
    input  logic               sel_fast_i,
    input  logic [SHIFT_W-1:0] shift_i,
    input  logic               run_i,
    input  logic               clr_i,
    output logic               tick_o
);
    localparam int PRE_W = (1 << SHIFT_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       src;
    logic [PRE_W-1:0] mask;

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        src    = sel_fast_i ? fast_i : slow_i;
        mask   = ~({PRE_W{1'b1}} << shift_i);
        if (clr_i) begin
            st_d.pre = '0;
        end else if (run_i && src) begin
            tick_o   = ((st_q.pre & mask) == mask);
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
    import timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  cmp_mode_e mode_i,
    input  logic [W-1:0] count_i,
    input  logic [W-1:0] cmp_i,
    input  logic      tick_i,
    input  logic      w1c_i,
    output logic      status_o,
    output logic      event_o,
    output logic      restart_o
);
    typedef struct packed {
        logic status;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic       fire;

    always_comb begin
        st_d = st_q;
        fire = tick_i && (count_i >= cmp_i);
        unique case (mode_i)
            CMP_OFF: st_d.status = 1'b0;
            CMP_EQ:  st_d.status = (count_i == cmp_i);
            CMP_GE:  st_d.status = (count_i >= cmp_i);
            CMP_EVT: begin
                if (fire) begin
                    st_d.status = 1'b1;
                end else if (w1c_i) begin
                    st_d.status = 1'b0;
                end
            end
            default: st_d.status = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o  = st_q.status;
    assign event_o   = st_q.status && (mode_i == CMP_EVT);
    assign restart_o = fire && (mode_i == CMP_EVT);

endmodule

// File: rtl/tmr_setup.sv
module tmr_setup
    import timer_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              en_o,
    output logic [CFG_W-1:0]  cfg_o,
    output logic              locked_o
);
    typedef struct packed {
        logic             en;
        logic             locked;
        logic [CFG_W-1:0] cfg;
    } setup_state_t;

    setup_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.en = wdata_i[BIT_EN];
            if (!st_q.locked) begin
                st_d.cfg    = wdata_i[CFG_W-1:0];
                st_d.locked = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o     = st_q.en;
    assign cfg_o    = st_q.cfg;
    assign locked_o = st_q.locked;

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import timer_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              slow_tick_i,
    input  logic              fast_tick_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    localparam logic [N_CMP-1:0] RESTART_MASK = N_CMP'(1) << (N_CMP - 1);

    typedef struct packed {
        logic [N_CMP-1:0][DATA_W-1:0] cmp;
        logic [DATA_W-1:0]            count;
    } core_state_t;

    core_state_t st_d, st_q;

    logic             en;
    logic             locked;
    logic [CFG_W-1:0] cfg;
    logic             tick;
    logic             cnt_we;
    logic             setup_we;
    logic             restart;
    logic [N_CMP-1:0] status;
    logic [N_CMP-1:0] evt;
    logic [N_CMP-1:0] restart_vec;

    assign cnt_we   = reg_we_i && (reg_addr_i == ADDR_COUNT);
    assign setup_we = reg_we_i && (reg_addr_i == ADDR_SETUP);

    tmr_setup u_setup (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (setup_we),
        .wdata_i  (reg_wdata_i),
        .en_o     (en),
        .cfg_o    (cfg),
        .locked_o (locked)
    );

    tmr_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .slow_i     (slow_tick_i),
        .fast_i     (fast_tick_i),
        .sel_fast_i (cfg[BIT_SEL]),
        .shift_i    (cfg[SHIFT_W-1:0]),
        .run_i      (en),
        .clr_i      (cnt_we),
        .tick_o     (tick)
    );

    for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
        tmr_compare #(.W(DATA_W)) u_cmp (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .mode_i    (cmp_mode_e'(cfg[BIT_MODE_LO + 2*k +: 2])),
            .count_i   (st_q.count),
            .cmp_i     (st_q.cmp[k]),
            .tick_i    (tick),
            .w1c_i     (setup_we && reg_wdata_i[BIT_ST_LO + k]),
            .status_o  (status[k]),
            .event_o   (evt[k]),
            .restart_o (restart_vec[k])
        );
    end

    assign restart = |(restart_vec & RESTART_MASK);

    always_comb begin
        st_d = st_q;
        if (reg_we_i && (reg_addr_i == ADDR_CMP1)) begin
            st_d.cmp[0] = reg_wdata_i;
        end
        if (reg_we_i && (reg_addr_i == ADDR_CMP2)) begin
            st_d.cmp[1] = reg_wdata_i;
        end
        if (cnt_we) begin
            st_d.count = reg_wdata_i;
        end else if (tick) begin
            st_d.count = restart ? '0 : st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (reg_addr_i)
            ADDR_CMP1:  reg_rdata_o = st_q.cmp[0];
            ADDR_CMP2:  reg_rdata_o = st_q.cmp[1];
            ADDR_COUNT: reg_rdata_o = st_q.count;
            default:    reg_rdata_o = {en, status[1], status[0], locked, cfg};
        endcase
    end

    assign irq_o = |evt;

endmodule

// File: rtl/dual_cmp_timer_chk.sv
module dual_cmp_timer_chk
    import timer_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cnt_we,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] count,
    input logic              en,
    input logic              tick,
    input logic              restart,
    input logic              locked,
    input logic [CFG_W-1:0]  cfg,
    input logic [N_CMP-1:0]  status,
    input logic              irq
);

    assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && !cnt_we && !restart) |=> (count == DATA_W'($past(count) + 1'b1)));

    assert_cfg_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked |=> (locked && $stable(cfg)));

    assert_freeze_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en && !cnt_we) |=> $stable(count));

    assert_count_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_we |=> (count == $past(wdata)));

    assert_restart_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (restart && !cnt_we) |=> (count == '0));

    assert_irq_has_status_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq |-> (status != '0));

endmodule

bind dual_cmp_timer dual_cmp_timer_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_we  (cnt_we),
    .wdata   (reg_wdata_i),
    .count   (st_q.count),
    .en      (en),
    .tick    (tick),
    .restart (restart),
    .locked  (locked),
    .cfg     (cfg),
    .status  (status),
    .irq     (irq_o)
);

// File: tb/tb_dual_cmp_timer.sv
module tb_dual_cmp_timer;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        slow_tick_i = 1'b0;
    logic        fast_tick_i = 1'b1;
    logic        reg_we_i = 1'b0;
    logic [1:0]  reg_addr_i = 2'd0;
    logic [15:0] reg_wdata_i = 16'd0;
    logic [15:0] reg_rdata_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk_i = ~clk_i;

    dual_cmp_timer dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .slow_tick_i (slow_tick_i),
        .fast_tick_i (fast_tick_i),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o)
    );

    // {prescale n, enabled edges, expected count} for R2
    localparam logic [31:0] VEC [4] = '{
        {4'd0, 12'd10, 16'd10},
        {4'd1, 12'd11, 16'd5},
        {4'd2, 12'd10, 16'd2},
        {4'd3, 12'd40, 16'd5}
    };

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        reg_we_i = 1'b0;
        slow_tick_i = 1'b0;
        repeat (2) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_we_i = 1'b1;
        reg_addr_i = a;
        reg_wdata_i = d;
        @(negedge clk_i);
        reg_we_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    initial begin
        logic [15:0] v;
        @(negedge clk_i);
        do_reset();

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reg reset", v, 16'h0000);
        end
        chk("R1 irq reset", {15'd0, irq_o}, 16'd0);

        // R2 vector table
        for (int i = 0; i < 4; i++) begin
            do_reset();
            wr(2'd3, 16'h8010 | {12'd0, VEC[i][31:28]});
            idle(int'(VEC[i][27:16]));
            rd(2'd2, v);
            chk("R2 prescaled count", v, VEC[i][15:0]);
        end

        // R8 R9 R10 R5: periodic event on comparator 2
        do_reset();
        wr(2'd1, 16'd3);
        wr(2'd3, 16'hE310);
        idle(3);
        rd(2'd2, v); chk("R8 count before event", v, 16'd3);
        chk("R10 irq low before event", {15'd0, irq_o}, 16'd0);
        idle(1);
        rd(2'd2, v); chk("R8 restart to zero", v, 16'd0);
        chk("R10 irq on event", {15'd0, irq_o}, 16'd1);
        rd(2'd3, v); chk("R7 R8 setup readback", v, 16'hD310);
        wr(2'd3, 16'h8310);
        chk("R9 write 0 keeps status", {15'd0, irq_o}, 16'd1);
        wr(2'd3, 16'hC310);
        chk("R9 write 1 clears status", {15'd0, irq_o}, 16'd0);
        idle(2);
        rd(2'd2, v); chk("R8 second period restart", v, 16'd0);
        chk("R10 irq second period", {15'd0, irq_o}, 16'd1);
        wr(2'd3, 16'h4310);
        rd(2'd2, v); chk("R5 count at disable", v, 16'd1);
        idle(5);
        rd(2'd2, v); chk("R5 count frozen", v, 16'd1);
        chk("R9 cleared with disable", {15'd0, irq_o}, 16'd0);

        // R6 count write override, R4 write once
        do_reset();
        wr(2'd3, 16'h8010);
        idle(3);
        wr(2'd2, 16'd100);
        rd(2'd2, v); chk("R6 load overrides tick", v, 16'd100);
        idle(1);
        rd(2'd2, v); chk("R6 counts on from load", v, 16'd101);
        wr(2'd3, 16'h80FF);
        rd(2'd3, v); chk("R4 config locked", v, 16'h9010);

        // R3 source select
        do_reset();
        wr(2'd3, 16'h8000);
        idle(4);
        rd(2'd2, v); chk("R3 fast ignored on slow select", v, 16'd0);
        for (int p = 0; p < 3; p++) begin
            slow_tick_i = 1'b1;
            @(negedge clk_i);
            slow_tick_i = 1'b0;
            @(negedge clk_i);
        end
        rd(2'd2, v); chk("R3 slow strobes counted", v, 16'd3);

        // R7 equal mode on comparator 1
        do_reset();
        wr(2'd0, 16'd2);
        wr(2'd3, 16'h0050);
        wr(2'd2, 16'd2);
        idle(1);
        rd(2'd3, v); chk("R7 equal match status", v, 16'h3050);
        chk("R10 no irq outside event mode", {15'd0, irq_o}, 16'd0);
        wr(2'd2, 16'd3);
        idle(1);
        rd(2'd3, v); chk("R7 equal miss status", v, 16'h1050);

        // R7 greater-or-equal mode
        do_reset();
        wr(2'd0, 16'd5);
        wr(2'd3, 16'h0090);
        wr(2'd2, 16'd7);
        idle(1);
        rd(2'd3, v); chk("R7 ge above status", v, 16'h3090);
        wr(2'd2, 16'd4);
        idle(1);
        rd(2'd3, v); chk("R7 ge below status", v, 16'h1090);

        // R7 off mode
        do_reset();
        wr(2'd3, 16'h0010);
        idle(2);
        rd(2'd3, v); chk("R7 off mode status", v, 16'h1010);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk_i);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule